// File: doc/BRIEF.md
# Video Control Register Bank with Serial Write Port

This block receives register writes over a two-wire serial bus and keeps the control registers of a picture-in-picture engine. It acts as a write-only bus slave. A transfer begins with a START. The device address byte follows, then a register index byte, then any number of data bytes. After each data byte the index moves up by one, and this continues until STOP. The slave pulls the data line low to acknowledge. It answers its own write address and every index and data byte after that.

Each register slot has a shadow copy and an active copy. The active copies drive the engine through one flat output vector. One bit in the bank is a hold control. While hold is set, writes to the display-shaping registers go only to their shadow copies. Once hold is cleared, the pending values move to the active copies on the next rising edge of the main-channel vertical sync. This lets software change a whole window layout and have it take effect at a field boundary. Acquisition offsets, polarity settings and the hold register itself are not held, so they take effect as soon as the byte is received.

Top module: `pipctl_regbank`

## Requirements
- R1: The slave acknowledges only the address byte 0x2C (device address 0x16, write direction). Any other address byte, including the read byte 0x2D, gets no acknowledge, and the bytes that follow in that transfer change no register.
- R2: The byte after the address byte is the register index. Each data byte after it is written to the current index, and the index then increases by one. This continues until STOP.
- R3: The slave pulls the data line low during the ninth clock of the address byte (when R1 accepts it), of the index byte, and of every data byte. It changes the pull-down only while the synchronised bus clock is low.
- R4: The bank holds slots 0x00 to 0x14. A data byte sent to index 0x15 to 0x18 (reserved) or to any index above 0x18 is acknowledged and changes no register.
- R5: The non-held slots (0x06 to 0x0C, 0x0F and 0x10) copy a written byte to their active value in the cycle after the byte is received, whatever the hold state.
- R6: The held slots are 0x00 to 0x05, 0x0D, 0x0E and 0x11 to 0x14. While hold is clear, a byte written to a held slot reaches its active value at once, as in R5.
- R7: Hold is bit 7 of slot 0x10. While it is 1, the active values of held slots do not change. Bytes written to held slots are kept in their shadow copies.
- R8: After hold returns to 0, each held slot takes its shadow value on the next rising edge of the vertical sync input, and not before that edge.
- R9: A rising edge of vertical sync while hold is 1 leaves every held active value unchanged.
- R10: After reset, every active slot reads 0x00 except slot 0x14, which reads 0x22. In slot 0x14, bits 2:0 give the horizontal border width in two-pixel steps (code 2 = 4 pixels) and bits 6:4 give the vertical border width in lines (code 2 = 2 lines).
- R11: A START seen in any state, including in the middle of a transfer without a STOP, restarts the address phase. The new transfer then works as in R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Serial bus data line, as seen on the wire |
| vsync_i | input | 1 | Main-channel vertical sync |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| regs_o | output | 168 | Active register values; slot n is bits [8n+7:8n] |

## Verification
Some properties are checked on every cycle. The pull-down changes only while the bus clock is low. The register index steps by one after each data byte. A write to a reserved or out-of-range index leaves the shadow copies alone. Held active values stay frozen for as long as hold is set. A non-held slot shows its written byte on the next cycle. Other behaviour can only be shown by the directed scenarios at the ports: which address bytes are acknowledged, the reset contents, and the order of events around hold and sync. In particular, only a scenario shows that a pending value waits through a cleared hold until the next sync edge, and that a sync edge under hold moves nothing.

// File: rtl/pipctl_pkg.sv
package pipctl_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_ACK_A,
    RX_SUB,
    RX_ACK_S,
    RX_DATA,
    RX_ACK_D
  } rx_state_e;

  // Slots whose active copy waits for the sync transfer while hold is set.
  function automatic bit slot_is_held(input int s);
    case (s)
      0, 1, 2, 3, 4, 5, 13, 14, 17, 18, 19, 20: return 1'b1;
      default:                                  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pipctl_sync.sv
module pipctl_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pipctl_i2c_wr.sv
module pipctl_i2c_wr
  import pipctl_pkg::*;
#(
  parameter logic [7:0] DEV_BYTE = 8'h2C,
  parameter int         BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] sub_q, sub_d;
  logic              scl_p, sda_p;
  logic              start_c, stop_c, rise_c, fall_c, wr_c;

  assign start_c = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;
  assign rise_c  = scl_s & ~scl_p;
  assign fall_c  = ~scl_s & scl_p;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    sub_d = sub_q;
    wr_c  = 1'b0;
    if (start_c) begin
      st_d  = RX_ADDR;
      cnt_d = '0;
    end else if (stop_c) begin
      st_d = RX_IDLE;
    end else begin
      case (st_q)
        RX_ADDR, RX_SUB, RX_DATA: begin
          if (rise_c && cnt_q < FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (fall_c && cnt_q == FULL) begin
            if (st_q == RX_ADDR) begin
              st_d = (sh_q == DEV_BYTE) ? RX_ACK_A : RX_IDLE;
            end else if (st_q == RX_SUB) begin
              sub_d = sh_q;
              st_d  = RX_ACK_S;
            end else begin
              wr_c  = 1'b1;
              sub_d = sub_q + 1'b1;
              st_d  = RX_ACK_D;
            end
          end
        end
        RX_ACK_A: if (fall_c) begin st_d = RX_SUB;  cnt_d = '0; end
        RX_ACK_S: if (fall_c) begin st_d = RX_DATA; cnt_d = '0; end
        RX_ACK_D: if (fall_c) begin st_d = RX_DATA; cnt_d = '0; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      sub_q <= '0;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      sub_q <= sub_d;
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign sda_pull_o = (st_q == RX_ACK_A) || (st_q == RX_ACK_S) || (st_q == RX_ACK_D);
  assign wr_en_o    = wr_c;
  assign wr_addr_o  = sub_q;
  assign wr_data_o  = sh_q;

  // R3: acknowledge line moves only while the clock is low
  assert_pull_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s);

  // R2: index steps by one after every data byte
  assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (sub_q == $past(sub_q) + 1'b1));

endmodule

// File: rtl/pipctl_shadow_bank.sv
module pipctl_shadow_bank
  import pipctl_pkg::*;
#(
  parameter int         NUM_IMPL    = 21,
  parameter int         HOLD_SLOT   = 16,
  parameter int         HOLD_BIT    = 7,
  parameter int         BORDER_SLOT = 20,
  parameter logic [7:0] BORDER_RST  = 8'h22
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [7:0]               wr_addr_i,
  input  logic [7:0]               wr_data_i,
  input  logic                     vsync_s,
  output logic [NUM_IMPL-1:0][7:0] active_o
);
  localparam logic [7:0] IMPL_LIM = 8'(NUM_IMPL);

  logic [NUM_IMPL-1:0][7:0] shadow_q, shadow_d;
  logic [NUM_IMPL-1:0][7:0] active_q, active_d;
  logic                     vs_p, vs_rise, hold;

  assign vs_rise = vsync_s & ~vs_p;
  assign hold    = active_q[HOLD_SLOT][HOLD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_p <= 1'b0;
    else        vs_p <= vsync_s;
  end

  for (genvar i = 0; i < NUM_IMPL; i++) begin : g_slot
    localparam bit         HELD = slot_is_held(i);
    localparam logic [7:0] RSTV = (i == BORDER_SLOT) ? BORDER_RST : 8'h00;
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == 8'(i));

    always_comb begin
      shadow_d[i] = shadow_q[i];
      active_d[i] = active_q[i];
      if (HELD && vs_rise && !hold) active_d[i] = shadow_q[i];
      if (hit) begin
        shadow_d[i] = wr_data_i;
        if (!HELD || !hold) active_d[i] = wr_data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[i] <= RSTV;
        active_q[i] <= RSTV;
      end else begin
        shadow_q[i] <= shadow_d[i];
        active_q[i] <= active_d[i];
      end
    end

    if (HELD) begin : g_held_chk
      // R7: held outputs frozen while hold was set
      assert_held_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> $stable(active_q[i]));
    end else begin : g_free_chk
      // R5: free slots follow a write on the next cycle
      assert_free_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (active_q[i] == $past(wr_data_i)));
    end
  end

  assign active_o = active_q;

  // R4: writes beyond the implemented slots leave storage untouched
  assert_reserved_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i >= IMPL_LIM) |=> $stable(shadow_q));

endmodule

// File: rtl/pipctl_regbank.sv
module pipctl_regbank #(
  parameter logic [7:0] DEV_BYTE    = 8'h2C,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_IMPL    = 21,
  parameter int         HOLD_SLOT   = 16,
  parameter int         HOLD_BIT    = 7,
  parameter int         BORDER_SLOT = 20,
  parameter logic [7:0] BORDER_RST  = 8'h22
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  vsync_i,
  output logic                  sda_pull_o,
  output logic [NUM_IMPL*8-1:0] regs_o
);
  logic [1:0] bus_s;
  logic       vs_s;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data;
  logic [NUM_IMPL-1:0][7:0] active;

  pipctl_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(bus_s));

  pipctl_sync #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b0)) u_vs_sync (
    .clk(clk), .rst_n(rst_n), .d_i(vsync_i), .q_o(vs_s));

  pipctl_i2c_wr #(.DEV_BYTE(DEV_BYTE), .BYTE_W(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .sda_pull_o(sda_pull_o), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data));

  pipctl_shadow_bank #(
    .NUM_IMPL(NUM_IMPL), .HOLD_SLOT(HOLD_SLOT), .HOLD_BIT(HOLD_BIT),
    .BORDER_SLOT(BORDER_SLOT), .BORDER_RST(BORDER_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .vsync_s(vs_s), .active_o(active));

  assign regs_o = active;
endmodule

// File: tb/pipctl_regbank_tb.sv
module pipctl_regbank_tb;
  localparam int N = 21;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic vsync = 1'b0;
  logic sda_pull;
  logic [N*8-1:0] regs;
  wire  sda_line = sda_drv & ~sda_pull;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [7:0] wbuf [0:7];

  always #2 clk = ~clk;

  pipctl_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .vsync_i(vsync), .sda_pull_o(sda_pull), .regs_o(regs));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] slot(input int s);
    return regs[s*8 +: 8];
  endfunction

  task automatic bus_start();
    sda_drv = 1'b1; tick(Q);
    scl = 1'b1;     tick(Q);
    sda_drv = 1'b0; tick(Q);
    scl = 1'b0;     tick(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(Q);
    scl = 1'b1;     tick(Q);
    sda_drv = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int k = 7; k >= 0; k--) begin
      sda_drv = b[k]; tick(Q);
      scl = 1'b1;     tick(Q);
      scl = 1'b0;
    end
    sda_drv = 1'b1; tick(Q);
    scl = 1'b1;     tick(Q/2);
    acked = ~sda_line;
    tick(Q - Q/2);
    scl = 1'b0;
    tick(2);
  endtask

  // transfer: address byte, index, then n bytes from wbuf
  task automatic xfer(input logic [7:0] ab, input logic [7:0] sub, input int n,
                      input logic exp_ack, input string req, input logic do_stop);
    logic a;
    bus_start();
    send_byte(ab, a);
    chk({req, " address ack"}, a, exp_ack);
    send_byte(sub, a);
    if (exp_ack) chk("R3 index ack", a, 1'b1);
    for (int j = 0; j < n; j++) begin
      send_byte(wbuf[j], a);
      if (exp_ack) chk("R3 data ack", a, 1'b1);
    end
    if (do_stop) bus_stop();
    tick(4);
  endtask

  task automatic vs_pulse();
    vsync = 1'b1; tick(6);
    vsync = 1'b0; tick(8);
  endtask

  task automatic t_reset();
    for (int s = 0; s < N; s++)
      chk("R10 reset value", slot(s), (s == 20) ? 8'h22 : 8'h00);
  endtask

  task automatic t_address();
    logic [N*8-1:0] snap;
    snap = regs;
    wbuf[0] = 8'hA5;
    xfer(8'h2E, 8'h08, 1, 1'b0, "R1 foreign", 1'b1);
    xfer(8'h2D, 8'h08, 1, 1'b0, "R1 read byte", 1'b1);
    chk("R1 no change after refused address", regs, snap);
  endtask

  task automatic t_burst();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    xfer(8'h2C, 8'h08, 3, 1'b1, "R1", 1'b1);
    chk("R2 first byte", slot(8), 8'h11);
    chk("R2 increment", slot(9), 8'h22);
    chk("R5 third byte", slot(10), 8'h33);
  endtask

  task automatic t_held_open();
    wbuf[0] = 8'h3C;
    xfer(8'h2C, 8'h01, 1, 1'b1, "R1", 1'b1);
    chk("R6 held slot open", slot(1), 8'h3C);
  endtask

  task automatic t_hold_cycle();
    wbuf[0] = 8'h80;
    xfer(8'h2C, 8'h10, 1, 1'b1, "R1", 1'b1);
    chk("R7 hold set", slot(16), 8'h80);
    wbuf[0] = 8'h5A;
    xfer(8'h2C, 8'h03, 1, 1'b1, "R1", 1'b1);
    wbuf[0] = 8'h77;
    xfer(8'h2C, 8'h0B, 1, 1'b1, "R1", 1'b1);
    chk("R7 held slot frozen", slot(3), 8'h00);
    chk("R5 free slot under hold", slot(11), 8'h77);
    vs_pulse();
    chk("R9 sync under hold", slot(3), 8'h00);
    wbuf[0] = 8'h00;
    xfer(8'h2C, 8'h10, 1, 1'b1, "R1", 1'b1);
    chk("R8 not before sync", slot(3), 8'h00);
    vs_pulse();
    chk("R8 transfer on sync", slot(3), 8'h5A);
    chk("R8 untouched slot", slot(1), 8'h3C);
  endtask

  task automatic t_reserved();
    logic [N*8-1:0] snap;
    wbuf[0] = 8'h41; wbuf[1] = 8'hEE; wbuf[2] = 8'hDD;
    snap = regs;
    snap[20*8 +: 8] = 8'h41;
    xfer(8'h2C, 8'h14, 3, 1'b1, "R1", 1'b1);
    chk("R4 reserved span", regs, snap);
    wbuf[0] = 8'h99;
    xfer(8'h2C, 8'h30, 1, 1'b1, "R1", 1'b1);
    chk("R4 out of range", regs, snap);
  endtask

  task automatic t_restart();
    wbuf[0] = 8'h44;
    xfer(8'h2C, 8'h09, 1, 1'b1, "R11", 1'b0);
    wbuf[0] = 8'h55;
    xfer(8'h2C, 8'h0C, 1, 1'b1, "R11", 1'b1);
    chk("R11 before restart", slot(9), 8'h44);
    chk("R11 after restart", slot(12), 8'h55);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_address();
    t_burst();
    t_held_open();
    t_hold_cycle();
    t_reserved();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule